// File: doc/BRIEF.md
# Register-Mapped GPIO Port

A parameterised general-purpose I/O port that sits on a simple synchronous register bus. Software reaches it through five word registers: a level register that reports what every line currently carries, a pair of atomic set and clear registers that change individual output bits without a read-modify-write, and two direction registers, one where a 1 means "drive" and one where a 1 means "listen". The two direction registers share a single direction state, so they always read back as complements and a line can never be claimed as both input and output.

Each line has an output value, an output enable and a pad input. The pad input is brought through a two-stage synchronizer before it reaches the read path. Build-time options select whether the clear register exists (without it the set register is a plain output latch), whether line numbering is bit-mirrored (line n sits at register bit W-1-n), and whether bus data is byte-reversed (only for 16- and 32-bit widths). Register addresses are word indices: 0 level, 1 set, 2 clear, 3 drive-direction, 4 listen-direction; 5 to 7 are unmapped.

Top module: `gpio_regs`

## Requirements
- R1: After reset every line is an input (enable low), the output latch is zero, the drive-direction register reads 0 and the listen-direction register reads all ones.
- R2: With the clear register built in, a write to address 1 drives high every line whose mapped bit is 1 and leaves lines with a 0 bit unchanged.
- R3: A write to address 2 drives low every line whose mapped bit is 1 and leaves the others unchanged; address 2 reads as zero.
- R4: Without the clear register, a write to address 1 loads the whole latch (1 high, 0 low), and address 2 ignores writes and reads zero.
- R5: A write to address 3 makes lines with a 1 bit outputs (enable high) and lines with a 0 bit inputs; address 3 reads back the direction.
- R6: A write to address 4 makes lines with a 1 bit inputs and lines with a 0 bit outputs; addresses 3 and 4 always read as bitwise complements.
- R7: Address 0 reads the latch for output lines and the synchronized pad for input lines; a pad value present at clock edge k is returned by a read captured at edge k+2 and not by one captured at edge k+1.
- R8: Writes to address 0 change neither outputs, enables nor any readback.
- R9: Address 1 reads the output latch, not the pad level.
- R10: With mirroring enabled, line n corresponds to register bit W-1-n; without it, to bit n.
- R11: With byte reversal enabled and W of 16 or 32, bus byte i carries register byte W/8-1-i in both directions; at W of 8 the option has no effect.
- R12: Addresses 5 to 7 read zero and ignore writes.
- R13: Read data is registered: it changes only on the edge that captures a read and holds otherwise; a write and a read of the same address in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register word address |
| wrEn | input | 1 | Write strobe |
| wrData | input | WIDTH | Write data in bus order |
| rdEn | input | 1 | Read strobe |
| rdData | output | WIDTH | Registered read data in bus order |
| padIn | input | WIDTH | Pad levels, one per line |
| gpioOut | output | WIDTH | Output value, one per line |
| gpioOe | output | WIDTH | Output enable, one per line |

## Verification
The register write and the register read share one address and can fall in the same cycle, and the interesting case is a write and a read of the same register together, or a direction change landing while a level read is in flight. The bench issues a combined write-and-read to the drive-direction register and judges that the returned word is the pre-write direction while the enables show the new one on the following cycle. Random traffic interleaves pad changes with reads and writes and compares every returned word against a model that applies the bit-mirror and byte-reversal rules independently.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  // Word addresses of the register file
  localparam int ADR_LEVEL  = 0;
  localparam int ADR_SET    = 1;
  localparam int ADR_CLR    = 2;
  localparam int ADR_DIROUT = 3;
  localparam int ADR_DIRIN  = 4;

  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_LATCH,
    SEL_DIROUT,
    SEL_DIRIN,
    SEL_ZERO
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   setStb;
    logic   clrStb;
    logic   loadStb;
    logic   dirOutStb;
    logic   dirInStb;
    logic   rdStb;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_regs_ctrl.sv
module gpio_regs_ctrl
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter bit HAS_CLEAR = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           stb
);

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_ZERO;
    stb.rdStb = rdEn;
    if (addr == ADDR_W'(ADR_LEVEL)) begin
      stb.rdSel = SEL_LEVEL;
    end else if (addr == ADDR_W'(ADR_SET)) begin
      stb.rdSel   = SEL_LATCH;
      stb.setStb  = wrEn && HAS_CLEAR;
      stb.loadStb = wrEn && !HAS_CLEAR;
    end else if (addr == ADDR_W'(ADR_CLR)) begin
      stb.clrStb = wrEn && HAS_CLEAR;
    end else if (addr == ADDR_W'(ADR_DIROUT)) begin
      stb.rdSel     = SEL_DIROUT;
      stb.dirOutStb = wrEn;
    end else if (addr == ADDR_W'(ADR_DIRIN)) begin
      stb.rdSel    = SEL_DIRIN;
      stb.dirInStb = wrEn;
    end
  end

endmodule

// File: rtl/gpio_regs_dp.sv
module gpio_regs_dp
  import gpio_regs_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter bit MIRROR    = 1'b1,
  parameter bit BYTE_SWAP = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] lineOut,
  output logic [WIDTH-1:0] lineOe
);

  localparam int NBYTES  = WIDTH / 8;
  localparam bit SWAP_EN = BYTE_SWAP && (WIDTH == 16 || WIDTH == 32);

  logic [WIDTH-1:0] wrReg, wrLine;
  logic [WIDTH-1:0] rdLine, rdReg, rdBus;
  logic [WIDTH-1:0] latchQ, dirQ, syncA, syncB, rdQ;
  logic [WIDTH-1:0] levelNow;

  // Bus order <-> register order
  generate
    if (SWAP_EN) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign wrReg[b*8 +: 8] = wrData[(NBYTES-1-b)*8 +: 8];
        assign rdBus[b*8 +: 8] = rdReg[(NBYTES-1-b)*8 +: 8];
      end
    end else begin : g_noswap
      assign wrReg = wrData;
      assign rdBus = rdReg;
    end
  endgenerate

  // Register order <-> line order
  generate
    if (MIRROR) begin : g_mirror
      for (genvar n = 0; n < WIDTH; n++) begin : g_bit
        assign wrLine[n]         = wrReg[WIDTH-1-n];
        assign rdReg[WIDTH-1-n]  = rdLine[n];
      end
    end else begin : g_straight
      assign wrLine = wrReg;
      assign rdReg  = rdLine;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (stb.loadStb) begin
      latchQ <= wrLine;
    end else if (stb.setStb) begin
      latchQ <= latchQ | wrLine;
    end else if (stb.clrStb) begin
      latchQ <= latchQ & ~wrLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (stb.dirOutStb) begin
      dirQ <= wrLine;
    end else if (stb.dirInStb) begin
      dirQ <= ~wrLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign levelNow = (dirQ & latchQ) | (~dirQ & syncB);

  always_comb begin
    case (stb.rdSel)
      SEL_LEVEL:  rdLine = levelNow;
      SEL_LATCH:  rdLine = latchQ;
      SEL_DIROUT: rdLine = dirQ;
      SEL_DIRIN:  rdLine = ~dirQ;
      default:    rdLine = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (stb.rdStb) begin
      rdQ <= rdBus;
    end
  end

  assign rdData  = rdQ;
  assign lineOut = latchQ;
  assign lineOe  = dirQ;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_regs_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int ADDR_W    = 3,
  parameter bit HAS_CLEAR = 1'b1,
  parameter bit MIRROR    = 1'b1,
  parameter bit BYTE_SWAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              rdEn,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  gpioOut,
  output logic [WIDTH-1:0]  gpioOe
);

  strobe_t stb;

  gpio_regs_ctrl #(
    .ADDR_W   (ADDR_W),
    .HAS_CLEAR(HAS_CLEAR)
  ) u_ctrl (
    .addr(addr),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .stb (stb)
  );

  gpio_regs_dp #(
    .WIDTH    (WIDTH),
    .MIRROR   (MIRROR),
    .BYTE_SWAP(BYTE_SWAP)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .padIn  (padIn),
    .rdData (rdData),
    .lineOut(gpioOut),
    .lineOe (gpioOe)
  );

endmodule

// File: rtl/gpio_regs_chk.sv
module gpio_regs_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [WIDTH-1:0]  rdData,
  input logic [WIDTH-1:0]  gpioOut,
  input logic [WIDTH-1:0]  gpioOe
);

  // R1: leaving reset, all lines are undriven inputs with a clear latch
  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (gpioOe == '0 && gpioOut == '0));

  // R5: outputs and enables move only in response to a write
  p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(gpioOut) && $stable(gpioOe)));

  // R8: level register writes leave the port untouched
  p_level_write_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0)) |=> ($stable(gpioOut) && $stable(gpioOe)));

  // R12: unmapped addresses return zero
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr >= ADDR_W'(5)) |=> (rdData == '0));

  // R12: unmapped writes leave the port untouched
  p_unmapped_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr >= ADDR_W'(5)) |=> ($stable(gpioOut) && $stable(gpioOe)));

  // R13: read data holds between reads
  p_read_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind gpio_regs gpio_regs_chk #(
  .WIDTH (WIDTH),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .rdData (rdData),
  .gpioOut(gpioOut),
  .gpioOe (gpioOe)
);

// File: tb/test_gpio_regs.sv
module test_gpio_regs;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic        wrA, rdA, wrB, rdB, wrC, rdC;
  logic [31:0] padA, rdDataA, outA, oeA;
  logic [15:0] padB, rdDataB, outB, oeB;
  logic [7:0]  padC, rdDataC, outC, oeC;

  // A: 32-bit, clear present, mirrored, byte-reversed
  gpio_regs i_gpio_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrA), .wrData(wdata),
    .rdEn(rdA), .rdData(rdDataA), .padIn(padA), .gpioOut(outA), .gpioOe(oeA));

  // B: 16-bit, no clear, straight, no reversal
  gpio_regs #(.WIDTH(16), .HAS_CLEAR(1'b0), .MIRROR(1'b0), .BYTE_SWAP(1'b0)) i_gpio_regs_b (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrB), .wrData(wdata[15:0]),
    .rdEn(rdB), .rdData(rdDataB), .padIn(padB), .gpioOut(outB), .gpioOe(oeB));

  // C: 8-bit, reversal requested but inapplicable
  gpio_regs #(.WIDTH(8), .HAS_CLEAR(1'b1), .MIRROR(1'b0), .BYTE_SWAP(1'b1)) i_gpio_regs_c (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrC), .wrData(wdata[7:0]),
    .rdEn(rdC), .rdData(rdDataC), .padIn(padC), .gpioOut(outC), .gpioOe(oeC));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Model of instance A, in line order
  logic [31:0] mLatch, mDir, mPad;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Mirror plus byte reversal at 32 bits reduces to a bit reversal inside each byte
  function automatic logic [31:0] mapA(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++)
        r[b*8+k] = v[b*8+7-k];
    return r;
  endfunction

  function automatic logic [31:0] expA(input logic [2:0] a, input logic [31:0] pad);
    case (a)
      3'd0:    return mapA((mDir & mLatch) | (~mDir & pad));
      3'd1:    return mapA(mLatch);
      3'd3:    return mapA(mDir);
      3'd4:    return mapA(~mDir);
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] l;
    l = mapA(d);
    case (a)
      3'd1: mLatch = mLatch | l;
      3'd2: mLatch = mLatch & ~l;
      3'd3: mDir   = l;
      3'd4: mDir   = ~l;
      default: ;
    endcase
  endtask

  // All bus tasks start and end just after a falling edge
  task automatic busWr(input int t, input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    wrA = (t == 0); wrB = (t == 1); wrC = (t == 2);
    @(posedge clk); @(negedge clk);
    wrA = 0; wrB = 0; wrC = 0;
  endtask

  task automatic busRd(input int t, input logic [2:0] a, output logic [31:0] v);
    addr = a;
    rdA = (t == 0); rdB = (t == 1); rdC = (t == 2);
    @(posedge clk); @(negedge clk);
    rdA = 0; rdB = 0; rdC = 0;
    v = (t == 0) ? rdDataA : (t == 1) ? {16'h0, rdDataB} : {24'h0, rdDataC};
  endtask

  task automatic busWrRdA(input logic [2:0] a, input logic [31:0] d, output logic [31:0] v);
    addr = a; wdata = d; wrA = 1; rdA = 1;
    @(posedge clk); @(negedge clk);
    wrA = 0; rdA = 0;
    v = rdDataA;
  endtask

  task automatic checkPortsA(input string req);
    chk(req, outA, mLatch);
    chk(req, oeA, mDir);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, oldPad;
    void'($urandom(32'd20240611));
    rstN = 0; addr = 0; wdata = 0;
    wrA = 0; rdA = 0; wrB = 0; rdB = 0; wrC = 0; rdC = 0;
    padA = 0; padB = 0; padC = 0;
    mLatch = 0; mDir = 0; mPad = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    checkPortsA("R1");
    busRd(0, 3'd3, v); chk("R1 dirout", v, 32'h0);
    busRd(0, 3'd4, v); chk("R1 dirin", v, 32'hFFFF_FFFF);
    busRd(0, 3'd1, v); chk("R1 latch", v, 32'h0);

    // R10 R11: bus bit 0 lands on line 7
    busWr(0, 3'd1, 32'h0000_0001); modelWr(3'd1, 32'h0000_0001);
    chk("R10 R11 line7", outA, 32'h0000_0080);
    // R2: further set leaves line 7 alone, bus bit 15 -> line 8
    busWr(0, 3'd1, 32'h0000_8000); modelWr(3'd1, 32'h0000_8000);
    chk("R2 set keeps", outA, 32'h0000_0180);
    // R3: clear line 7 only
    busWr(0, 3'd2, 32'h0000_0001); modelWr(3'd2, 32'h0000_0001);
    chk("R3 clear", outA, 32'h0000_0100);
    busRd(0, 3'd2, v); chk("R3 clr reads zero", v, 32'h0);

    // R5: drive direction
    busWr(0, 3'd3, 32'h0000_00FF); modelWr(3'd3, 32'h0000_00FF);
    chk("R5 oe", oeA, 32'h0000_00FF);
    busRd(0, 3'd3, v); chk("R5 readback", v, 32'h0000_00FF);
    busRd(0, 3'd4, v); chk("R6 complement", v, 32'hFFFF_FF00);
    // R6: listen direction, bus bits 0..3 -> lines 4..7 listen... complement drives
    busWr(0, 3'd4, 32'hFFFF_FFF0); modelWr(3'd4, 32'hFFFF_FFF0);
    chk("R6 oe", oeA, 32'h0000_00F0);
    busRd(0, 3'd3, v); chk("R6 dirout", v, 32'h0000_000F);

    // R9: set register reads latch, not pads
    padA = 32'hFFFF_FFFF; mPad = padA;
    repeat (2) @(negedge clk);
    busRd(0, 3'd1, v); chk("R9 latch not pad", v, mapA(mLatch));

    // R7 synchronizer latency
    oldPad = mPad;
    padA = 32'h5A5A_1234; mPad = padA;
    busRd(0, 3'd0, v); chk("R7 edge k", v, expA(3'd0, oldPad));
    busRd(0, 3'd0, v); chk("R7 edge k+1", v, expA(3'd0, oldPad));
    busRd(0, 3'd0, v); chk("R7 edge k+2", v, expA(3'd0, mPad));

    // R8: writes to level register ignored
    busWr(0, 3'd0, 32'hDEAD_BEEF);
    checkPortsA("R8");
    busRd(0, 3'd0, v); chk("R8 level", v, expA(3'd0, mPad));

    // R12: unmapped
    busWr(0, 3'd5, 32'hFFFF_FFFF);
    busWr(0, 3'd7, 32'hFFFF_FFFF);
    checkPortsA("R12");
    busRd(0, 3'd6, v); chk("R12 read", v, 32'h0);

    // R13: write and read of the same register in one cycle
    busRd(0, 3'd1, v);
    busWrRdA(3'd3, 32'h0F0F_0F0F, v);
    chk("R13 pre-write value", v, expA(3'd3, mPad));
    modelWr(3'd3, 32'h0F0F_0F0F);
    chk("R13 new oe", oeA, mDir);
    @(negedge clk);
    chk("R13 hold", rdDataA, mapA(32'h0000_00F0));

    // R4: instance without clear
    busWr(1, 3'd1, 32'h0000_A5A5); chk("R4 load", {16'h0, outB}, 32'h0000_A5A5);
    busWr(1, 3'd1, 32'h0000_0F00); chk("R4 load zeros", {16'h0, outB}, 32'h0000_0F00);
    busWr(1, 3'd2, 32'h0000_FFFF); chk("R4 clr ignored", {16'h0, outB}, 32'h0000_0F00);
    busRd(1, 3'd2, v); chk("R4 clr reads zero", v, 32'h0);
    busRd(1, 3'd1, v); chk("R4 latch read", v, 32'h0000_0F00);
    busWr(1, 3'd3, 32'h0000_0003); chk("R10 straight oe", {16'h0, oeB}, 32'h0000_0003);

    // R11: reversal has no effect at 8 bits
    busWr(2, 3'd1, 32'h0000_0001); chk("R11 w8 out", {24'h0, outC}, 32'h0000_0001);
    busWr(2, 3'd3, 32'h0000_0002); chk("R11 w8 oe", {24'h0, oeC}, 32'h0000_0002);
    busRd(2, 3'd3, v); chk("R11 w8 read", v, 32'h0000_0002);

    // Random traffic on A
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [2:0] a;
      logic [31:0] d;
      op = $urandom % 4;
      a  = 3'($urandom % 8);
      d  = $urandom;
      case (op)
        0: begin
          padA = $urandom; mPad = padA;
          repeat (2) @(negedge clk);
        end
        1: begin
          busWr(0, a, d); modelWr(a, d);
          checkPortsA("R2 R3 R5 R6 random write");
        end
        2: begin
          busRd(0, a, v);
          chk("R7 R9 R10 R11 random read", v, expA(a, mPad));
        end
        default: begin
          a = ($urandom % 2 == 0) ? 3'd1 : 3'd2;
          busWr(0, a, d); modelWr(a, d);
          checkPortsA("R2 R3 random set/clear");
        end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule